// File: doc/BRIEF.md
# DRAM Region Access Timer

This block decides how long each processor access to a DRAM region takes and drives the row and column strobes for it. The processor side presents an address, a read/write flag, a burst flag and a valid signal. The request is held until the block raises ready for a single clock. The memory side gets one row strobe per bank, active low, for up to four banks. It also gets a set of column strobes, one per byte lane of the memory, all active low, and an active-low write enable.

Latency depends on what happened just before the access, and it is fixed in hardware. An access that follows an idle cycle takes three cycles, because the row lines have already recovered. An access that directly follows another access must first spend one cycle with every row strobe released, so it takes four cycles.

A build parameter can enable page mode. With page mode on, the bank stays open after an access. A directly following access to the same bank and row then skips the row strobe and takes three cycles. A beat flagged as a burst that stays inside the open row takes two cycles. A second parameter selects a 16- or 32-bit memory width, and this moves the row field within the address.

Top module: `dram_region_timer`

## Requirements
- R1: A request accepted in the cycle after an idle cycle (no ready in the previous cycle) completes with ready in its third cycle, the acceptance cycle counted as the first, unless R4 applies.
- R2: A request presented in the cycle right after another access's ready cycle, and not a page hit, completes in its fourth cycle. In its second cycle every row strobe is high (the precharge cycle).
- R3: In page mode, a non-burst request presented right after a ready cycle is a page hit when its bank is open and its row equals that bank's open row. A page hit completes in three cycles and the row strobe stays low throughout.
- R4: In page mode, a page hit flagged as a burst completes in two cycles. A burst flag on a request that is not a page hit changes nothing.
- R5: With page mode off, no request is ever a page hit, and every row strobe is high in the cycle after each ready cycle.
- R6: Ready is high for exactly one clock per request. In that clock, the latency output equals the request's cycle count (2, 3 or 4); at all other times it is 0.
- R7: At most one row strobe is low at a time. The set of low row strobes never changes from one non-empty set to another without a cycle where all row strobes are high in between.
- R8: The bank is taken from the top two address bits. The row field starts just above the column field, which is 8 bits wide. Below the column field are the byte-offset bits: 2 of them at 32-bit width, 1 at 16-bit width. In the final cycle of an access, only the selected bank's row strobe is low.
- R9: In page mode, an idle cycle closes every open row, so all row strobes are high from the next cycle onwards.
- R10: During reset and in the first cycle after it, ready is low, the latency output is 0, and all row strobes, column strobes and the write enable are high.
- R11: All column strobes are low in the final cycle of each access and high otherwise, and column strobes are only low while a row strobe is low. The write enable is low in the final cycle of a write access only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present; held until ready |
| req_addr | input | ADDR_W | Byte address within the region |
| req_write | input | 1 | 1 for a write access |
| req_burst | input | 1 | Request is a burst beat |
| req_ready | output | 1 | One-clock completion pulse |
| acc_cycles | output | 3 | Cycle count of the completing access, 0 otherwise |
| ras_n | output | NUM_BANKS | Row strobes, one per bank, active low |
| cas_n | output | MEM_W/8 | Column strobes, one per byte lane, active low |
| mem_we_n | output | 1 | Write enable, active low |

## Verification
The hardest state to reach from the ports is a page hit. It needs the page-mode instance to have just completed an access to the same bank and row, with the new request arriving exactly in the cycle after ready. A single idle cycle in between turns it into a three-cycle full access instead of a hit. The bench therefore issues chains of requests with no gap, moving between same-row, other-row and other-bank targets and toggling the burst flag. It then places single and double idle cycles to show that rows are closed. The same pattern runs against a second instance with page mode off and a 16-bit width. That instance yields the non-page sequence 3,4,4,4, then idle, then 3, and it shows that the row field shifts with the width.

// File: rtl/drt_pkg.sv
// Shared types for the DRAM region access timer.
// Assumes latencies of at most 4 cycles, so a 3-bit count is enough.
package drt_pkg;

    typedef enum logic [1:0] {
        ACC_FULL_IDLE = 2'd0,   // full row access, recovery already met
        ACC_FULL_B2B  = 2'd1,   // full row access, needs a precharge cycle
        ACC_PAGE      = 2'd2,   // column-only access on the open row
        ACC_BURST     = 2'd3    // in-page burst beat
    } acc_kind_t;

    localparam int LAT_W = 3;

    // Fixed cycle count of each access kind
    function automatic logic [LAT_W-1:0] kind_latency(acc_kind_t kind);
        case (kind)
            ACC_FULL_IDLE: kind_latency = 3'd3;
            ACC_FULL_B2B:  kind_latency = 3'd4;
            ACC_PAGE:      kind_latency = 3'd3;
            default:       kind_latency = 3'd2;
        endcase
    endfunction

endpackage

// File: rtl/drt_addr_split.sv
// Splits a region byte address into a bank index and a row number.
// Assumes the bank index occupies the top address bits and the row field
// starts at ROW_LSB; column and byte-offset bits are not needed here.
module drt_addr_split #(
    parameter int ADDR_W    = 24,
    parameter int BANK_BITS = 2,
    parameter int ROW_BITS  = 12,
    parameter int ROW_LSB   = 10
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [BANK_BITS-1:0] bank,
    output logic [ROW_BITS-1:0]  row
);

    // Pure field extraction
    always_comb begin
        bank = addr[ADDR_W-1 -: BANK_BITS];
        row  = addr[ROW_LSB +: ROW_BITS];
    end

endmodule

// File: rtl/drt_row_tracker.sv
// Keeps the open/closed state and the open row of every bank.
// A bank's open flag doubles as its row-valid bit, so releasing the row
// strobe always invalidates the stored row. Assumes open and close events
// never occur in the same cycle; open has priority if they do.
module drt_row_tracker #(
    parameter int NUM_BANKS = 4,
    parameter int BANK_BITS = 2,
    parameter int ROW_BITS  = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [BANK_BITS-1:0] look_bank,
    input  logic [ROW_BITS-1:0]  look_row,
    input  logic                 open_ev,
    input  logic [BANK_BITS-1:0] open_bank,
    input  logic [ROW_BITS-1:0]  open_row,
    input  logic                 close_ev,
    output logic                 row_hit,
    output logic [NUM_BANKS-1:0] bank_open
);

    logic [ROW_BITS-1:0] row_q [NUM_BANKS];

    // Open flags: set one bank on open, clear all on close
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_open <= '0;
        end else if (open_ev) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                bank_open[b] <= (open_bank == BANK_BITS'(b));
            end
        end else if (close_ev) begin
            bank_open <= '0;
        end
    end

    // Per-bank row register, loaded when that bank is opened
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_row
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                row_q[g] <= '0;
            end else if (open_ev && open_bank == BANK_BITS'(g)) begin
                row_q[g] <= open_row;
            end
        end
    end

    // Hit lookup for the presented request
    always_comb begin
        row_hit = bank_open[look_bank] && (row_q[look_bank] == look_row);
    end

endmodule

// File: rtl/drt_seq_ctrl.sv
// Accepts requests, classifies them, counts out the latency and produces
// the row open/close events and the column strobe timing.
// Assumes the requester holds valid and address stable until ready.
module drt_seq_ctrl
    import drt_pkg::*;
#(
    parameter bit PAGE_MODE = 1'b1,
    parameter int BANK_BITS = 2,
    parameter int ROW_BITS  = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_burst,
    input  logic [BANK_BITS-1:0] req_bank,
    input  logic [ROW_BITS-1:0]  req_row,
    input  logic                 row_hit,
    output logic                 ready,
    output logic [LAT_W-1:0]     lat_out,
    output logic                 col_active,
    output logic                 open_ev,
    output logic [BANK_BITS-1:0] open_bank,
    output logic [ROW_BITS-1:0]  open_row,
    output logic                 close_ev
);

    logic                 busy;
    logic [LAT_W-1:0]     remain;
    logic [LAT_W-1:0]     cur_lat;
    logic                 prev_ready;
    logic [BANK_BITS-1:0] tgt_bank;
    logic [ROW_BITS-1:0]  tgt_row;
    logic                 accept;
    acc_kind_t            kind;

    // Classify the presented request from the bus history
    always_comb begin
        accept = req_valid && !busy;
        if (PAGE_MODE && prev_ready && row_hit) begin
            kind = req_burst ? ACC_BURST : ACC_PAGE;
        end else begin
            kind = prev_ready ? ACC_FULL_B2B : ACC_FULL_IDLE;
        end
    end

    // Latency counter and target latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            remain     <= '0;
            cur_lat    <= '0;
            prev_ready <= 1'b0;
            tgt_bank   <= '0;
            tgt_row    <= '0;
        end else begin
            prev_ready <= ready;
            if (accept) begin
                busy     <= 1'b1;
                remain   <= kind_latency(kind) - 3'd1;
                cur_lat  <= kind_latency(kind);
                tgt_bank <= req_bank;
                tgt_row  <= req_row;
            end else if (busy) begin
                remain <= remain - 3'd1;
                if (remain == 3'd1) begin
                    busy <= 1'b0;
                end
            end
        end
    end

    // Completion and strobe timing outputs
    always_comb begin
        ready      = busy && (remain == 3'd1);
        lat_out    = ready ? cur_lat : '0;
        col_active = ready;
    end

    // Row events: open at row-strobe start, close for precharge or idle
    always_comb begin
        open_ev   = (accept && kind == ACC_FULL_IDLE) || (busy && remain == 3'd3);
        open_bank = accept ? req_bank : tgt_bank;
        open_row  = accept ? req_row : tgt_row;
        close_ev  = (accept && kind == ACC_FULL_B2B) || (!busy && !accept)
                    || (!PAGE_MODE && ready);
    end

endmodule

// File: rtl/dram_region_timer.sv
// Top of the DRAM region access timer: address split, row tracking and
// access sequencing. Assumes NUM_BANKS is 2 or 4 and MEM_W is 16 or 32.
module dram_region_timer #(
    parameter int ADDR_W    = 24,
    parameter int MEM_W     = 32,
    parameter int COL_BITS  = 8,
    parameter int NUM_BANKS = 4,
    parameter bit PAGE_MODE = 1'b1,
    localparam int LANES     = MEM_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_burst,
    output logic              req_ready,
    output logic [2:0]        acc_cycles,
    output logic [NUM_BANKS-1:0] ras_n,
    output logic [LANES-1:0]  cas_n,
    output logic              mem_we_n
);

    localparam int BYTE_BITS = (MEM_W == 32) ? 2 : 1;
    localparam int BANK_BITS = $clog2(NUM_BANKS);
    localparam int ROW_LSB   = BYTE_BITS + COL_BITS;
    localparam int ROW_BITS  = ADDR_W - BANK_BITS - ROW_LSB;

    logic [BANK_BITS-1:0] req_bank;
    logic [ROW_BITS-1:0]  req_row;
    logic                 row_hit;
    logic [NUM_BANKS-1:0] bank_open;
    logic                 col_active;
    logic                 open_ev;
    logic                 close_ev;
    logic [BANK_BITS-1:0] open_bank;
    logic [ROW_BITS-1:0]  open_row;

    drt_addr_split #(
        .ADDR_W(ADDR_W), .BANK_BITS(BANK_BITS),
        .ROW_BITS(ROW_BITS), .ROW_LSB(ROW_LSB)
    ) u_split (
        .addr(req_addr), .bank(req_bank), .row(req_row)
    );

    drt_row_tracker #(
        .NUM_BANKS(NUM_BANKS), .BANK_BITS(BANK_BITS), .ROW_BITS(ROW_BITS)
    ) u_rows (
        .clk(clk), .rst_n(rst_n),
        .look_bank(req_bank), .look_row(req_row),
        .open_ev(open_ev), .open_bank(open_bank), .open_row(open_row),
        .close_ev(close_ev), .row_hit(row_hit), .bank_open(bank_open)
    );

    drt_seq_ctrl #(
        .PAGE_MODE(PAGE_MODE), .BANK_BITS(BANK_BITS), .ROW_BITS(ROW_BITS)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_burst(req_burst),
        .req_bank(req_bank), .req_row(req_row), .row_hit(row_hit),
        .ready(req_ready), .lat_out(acc_cycles), .col_active(col_active),
        .open_ev(open_ev), .open_bank(open_bank), .open_row(open_row),
        .close_ev(close_ev)
    );

    // Active-low memory strobes
    always_comb begin
        ras_n    = ~bank_open;
        cas_n    = {LANES{~col_active}};
        mem_we_n = ~(col_active && req_write);
    end

endmodule

// File: rtl/drt_checker.sv
// Protocol checker for the DRAM region access timer, bound to the top.
// Uses ports only; counts request cycles itself to bound the latency.
module drt_checker #(
    parameter int NUM_BANKS = 4,
    parameter int LANES     = 4,
    parameter bit PAGE_MODE = 1'b1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic [2:0]           acc_cycles,
    input logic [NUM_BANKS-1:0] ras_n,
    input logic [LANES-1:0]     cas_n
);

    localparam logic [NUM_BANKS-1:0] ALL_HIGH = {NUM_BANKS{1'b1}};

    logic [2:0] wait_cnt;

    // Cycles the current request has waited before its ready cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_cnt <= '0;
        end else if (req_ready) begin
            wait_cnt <= '0;
        end else if (req_valid && wait_cnt != 3'd7) begin
            wait_cnt <= wait_cnt + 3'd1;
        end
    end

    assert_ready_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);

    assert_latency_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> acc_cycles == wait_cnt + 3'd1);

    assert_latency_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (acc_cycles >= 3'd2 && acc_cycles <= 3'd4));

    assert_one_row_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ras_n));

    assert_precharge_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n != ALL_HIGH && $past(ras_n) != ALL_HIGH) |-> ras_n == $past(ras_n));

    assert_cas_under_ras_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_n != {LANES{1'b1}}) |-> ras_n != ALL_HIGH);

    if (PAGE_MODE == 1'b0) begin : g_np
        assert_np_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $past(req_ready) |-> ras_n == ALL_HIGH);
    end

endmodule

bind dram_region_timer drt_checker #(
    .NUM_BANKS(NUM_BANKS), .LANES(LANES), .PAGE_MODE(PAGE_MODE)
) u_drt_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .acc_cycles(acc_cycles), .ras_n(ras_n), .cas_n(cas_n)
);

// File: tb/test_dram_region_timer.sv
// Bench: instance 0 is page mode at 32-bit width, instance 1 has page mode
// off at 16-bit width. A behavioural model predicts each latency from the
// access history and checks the ports in every cycle.
module test_dram_region_timer;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        v   [2];
    logic [23:0] a   [2];
    logic        wr  [2];
    logic        bu  [2];
    logic        rdy [2];
    logic [2:0]  lat [2];
    logic [3:0]  rn  [2];
    logic [3:0]  cas0;
    logic [1:0]  cas1;
    logic        we  [2];

    dram_region_timer #(.MEM_W(32), .PAGE_MODE(1'b1)) i_dram_region_timer (
        .clk(clk), .rst_n(rst_n), .req_valid(v[0]), .req_addr(a[0]),
        .req_write(wr[0]), .req_burst(bu[0]), .req_ready(rdy[0]),
        .acc_cycles(lat[0]), .ras_n(rn[0]), .cas_n(cas0), .mem_we_n(we[0])
    );

    dram_region_timer #(.MEM_W(16), .PAGE_MODE(1'b0)) i_dram_region_timer_np (
        .clk(clk), .rst_n(rst_n), .req_valid(v[1]), .req_addr(a[1]),
        .req_write(wr[1]), .req_burst(bu[1]), .req_ready(rdy[1]),
        .acc_cycles(lat[1]), .ras_n(rn[1]), .cas_n(cas1), .mem_we_n(we[1])
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Model state per instance
    bit m_prev_rdy [2];
    bit m_open     [2];
    int m_bank     [2];
    int m_row      [2];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit cas_all_low(input int m);
        return (m == 0) ? (cas0 == 4'h0) : (cas1 == 2'h0);
    endfunction

    function automatic bit cas_all_high(input int m);
        return (m == 0) ? (cas0 == 4'hF) : (cas1 == 2'h3);
    endfunction

    // One access: drive, predict, check every cycle until completion
    task automatic access(input int m, input int bank, input int row, input int col,
                          input bit burst, input bit write);
        int  bb;
        bit  b2b;
        bit  hit;
        int  exp_lat;
        bb  = (m == 0) ? 2 : 1;
        b2b = m_prev_rdy[m];
        hit = (m == 0) && b2b && m_open[m] && m_bank[m] == bank && m_row[m] == row;
        exp_lat = hit ? (burst ? 2 : 3) : (b2b ? 4 : 3);
        @(negedge clk);
        v[m]  = 1'b1;
        a[m]  = 24'((bank << 22) | (row << (8 + bb)) | (col << bb));
        wr[m] = write;
        bu[m] = burst;
        for (int k = 1; k <= exp_lat; k++) begin
            if (k > 1) @(negedge clk);
            #1;
            // R1 R2 R3 R4 R6: ready only in the predicted cycle
            chk(rdy[m] == (k == exp_lat), hit ? (burst ? "R4" : "R3") : (b2b ? "R2" : "R1"),
                int'(rdy[m]), int'(k == exp_lat));
            if (k == 2 && exp_lat == 4)
                chk(rn[m] == 4'hF, "R2 precharge", int'(rn[m]), 15);
            if (hit)
                chk(rn[m] == 4'(~(1 << bank)), "R3 row held", int'(rn[m]), int'(4'(~(1 << bank))));
            if (k == exp_lat) begin
                chk(lat[m] == 3'(exp_lat), "R6 latency", int'(lat[m]), exp_lat);
                chk(rn[m] == 4'(~(1 << bank)), "R8 bank strobe", int'(rn[m]),
                    int'(4'(~(1 << bank))));
                chk(cas_all_low(m) && we[m] == !write, "R11 final strobes",
                    int'(we[m]), int'(!write));
            end else begin
                chk(lat[m] == 3'd0 && cas_all_high(m), "R11 idle strobes", int'(lat[m]), 0);
            end
        end
        m_prev_rdy[m] = 1'b1;
        if (!hit) begin
            m_open[m] = (m == 0);
            m_bank[m] = bank;
            m_row[m]  = row;
        end
    endtask

    // Idle cycles: no request, rows close
    task automatic idle(input int m, input int n);
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            v[m] = 1'b0;
            #1;
            chk(rdy[m] == 1'b0 && lat[m] == 3'd0, "R6 no ready when idle", int'(rdy[m]), 0);
            if (m == 1 && i == 1)
                chk(rn[m] == 4'hF, "R5 rows released", int'(rn[m]), 15);
            if (i == 2)
                chk(rn[m] == 4'hF, "R9 rows closed", int'(rn[m]), 15);
        end
        m_prev_rdy[m] = 1'b0;
        m_open[m]     = 1'b0;
    endtask

    initial begin
        for (int m = 0; m < 2; m++) begin
            v[m] = 1'b0; a[m] = '0; wr[m] = 1'b0; bu[m] = 1'b0;
            m_prev_rdy[m] = 1'b0; m_open[m] = 1'b0; m_bank[m] = 0; m_row[m] = 0;
        end
        repeat (3) @(negedge clk);
        for (int m = 0; m < 2; m++)
            chk(rdy[m] == 1'b0 && rn[m] == 4'hF && cas_all_high(m) && we[m] && lat[m] == 0,
                "R10 reset state", int'(rn[m]), 15);
        rst_n = 1'b1;
        #1;
        for (int m = 0; m < 2; m++)
            chk(rdy[m] == 1'b0 && rn[m] == 4'hF && cas_all_high(m), "R10 after reset",
                int'(rn[m]), 15);

        // Page-mode instance
        idle(0, 2);
        access(0, 2, 7, 0, 1'b0, 1'b0);     // after idle: 3
        access(0, 2, 7, 1, 1'b0, 1'b1);     // page hit: 3
        access(0, 2, 7, 2, 1'b1, 1'b0);     // burst: 2
        access(0, 2, 7, 3, 1'b1, 1'b1);     // burst: 2
        access(0, 2, 8, 0, 1'b1, 1'b0);     // row miss, burst ignored: 4
        access(0, 2, 8, 5, 1'b0, 1'b0);     // hit on new row: 3
        access(0, 1, 8, 5, 1'b1, 1'b0);     // other bank: 4
        access(0, 1, 8, 6, 1'b1, 1'b1);     // burst: 2
        idle(0, 2);
        access(0, 1, 8, 7, 1'b1, 1'b0);     // closed by idle: 3
        access(0, 1, 8, 8, 1'b0, 1'b0);     // hit: 3
        access(0, 3, 4095, 255, 1'b0, 1'b1);// top row, last bank: 4
        idle(0, 1);
        access(0, 3, 4095, 255, 1'b0, 1'b0);// one idle cycle closes: 3
        idle(0, 2);

        // Non-page instance: 3,4,4,4, X, 3,4, X,X, 3, X, 3
        idle(1, 2);
        access(1, 0, 5, 0, 1'b0, 1'b0);
        access(1, 0, 5, 1, 1'b0, 1'b1);
        access(1, 1, 2, 0, 1'b0, 1'b0);
        access(1, 0, 5, 2, 1'b1, 1'b0);     // R5: no hit, burst ignored
        idle(1, 1);
        access(1, 2, 8191, 3, 1'b0, 1'b0);
        access(1, 2, 8191, 4, 1'b1, 1'b0);
        idle(1, 2);
        access(1, 3, 1, 0, 1'b0, 1'b1);
        idle(1, 1);
        access(1, 3, 1, 1, 1'b0, 1'b0);
        idle(1, 2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R6 watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule